// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block connects a CPU-style bus to three 8-bit peripheral ports (A, B and C). The bus side has a chip select, separate read and write strobes, two address bits and an 8-bit data bus. The data bus is split into a write-data input, a read-data output and a read-drive enable, so the chip top can build the tri-state pad. Each peripheral pin is also split into an input, an output value and an output enable.

Port C is split into two nibbles. The upper nibble works with port A as group A, and the lower nibble works with port B as group B. A write-only control register selects each group's mode and each port's direction. The two modes are basic I/O and strobed handshake. In strobed mode, three pins of the group's nibble become the strobe or acknowledge input, the buffer flag output and the interrupt request output. The same control address also accepts a command that sets or clears one port C bit. This command also loads the interrupt mask of a group.

The bus strobes are sampled on the clock. A write or read takes effect once per strobe assertion, on the first clock edge at which the strobe is seen active.

Top module: `par_io_ctrl`

## Requirements
- R1: After reset, every port pin enable is low. All three ports are inputs in basic mode, and all output latches hold zero.
- R2: A register is written only when chip select and the write strobe are both low. Read data is driven (`bus_rdata_oe` high) only when chip select and the read strobe are both low. Address 0 selects port A, address 1 port B, address 2 port C and address 3 the control register.
- R3: A read at address 3 never drives the data bus, so the control register contents are never returned.
- R4: A control word with bit 7 = 1 redefines the modes. The fields are: bit 6 = group A strobed, bit 5 = port A input, bit 4 = upper C input, bit 3 = group B strobed, bit 2 = port B input, bit 1 = lower C input. An output port drives its latch with its pin enables high.
- R5: In basic mode, an output port holds the last written value and reads back that latch. An input port read returns the live pin value.
- R6: A control word with bit 7 = 0 writes bit 0 into the port C latch bit selected by bits 3:1. The mode settings are left unchanged.
- R7: A mode-definition word clears all output latches, both interrupt masks, all buffer flags and all interrupt requests.
- R8: In strobed input mode, a low level on the group's strobe pin latches the port pins and raises the buffer-full pin. A later read returns the latched byte, not the current pins.
- R9: In strobed input mode, the interrupt request rises on the strobe's return high when the buffer is full and the mask is set. A read of the port clears both the buffer-full flag and the interrupt request.
- R10: In strobed output mode, a write to the port drives the active-low buffer-full pin low and clears the interrupt. A low acknowledge drives that pin high again. The interrupt rises when the acknowledge returns high with the buffer empty and the mask set.
- R11: If a port read meets the strobe's return high in the same cycle, the read wins and no interrupt is raised. If a port write meets a low acknowledge, the write wins and the buffer stays full.
- R12: Pin roles in a strobed nibble are fixed relative to the nibble's lowest bit. Offset 0 is the strobe/acknowledge input, offset 1 the buffer flag output, offset 2 the interrupt output, and offset 3 a general bit that follows the nibble direction. Group A uses bits 7:4 and group B uses bits 3:0.
- R13: A set/reset command for port C bit 4 loads the group A interrupt mask, and one for bit 0 loads the group B mask. With the mask clear, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Read data to the CPU |
| bus_rdata_oe | output | 1 | Read-data drive enable |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-bit drive enables |

## Verification
Two pairs of events can fall in the same cycle: a CPU read of port A and the peripheral strobe returning high, and a CPU write of port B and a low acknowledge. The bench provokes each pair by changing the strobe pin and the bus strobes on the same falling clock edge, so both are sampled at one rising edge. It then checks the flag and interrupt pins on the next falling edge. A correct result is a cleared flag with no interrupt in the first case, and a full output buffer with no interrupt in the second.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int HALF = DW / 2;
    localparam int IDXW = $clog2(DW);
    localparam int NGRP = 2;

    localparam logic [AW-1:0] ADR_A   = 2'd0;
    localparam logic [AW-1:0] ADR_B   = 2'd1;
    localparam logic [AW-1:0] ADR_C   = 2'd2;
    localparam logic [AW-1:0] ADR_CTL = 2'd3;

    // handshake pin offsets inside a port C nibble
    localparam int HS_STB  = 0;
    localparam int HS_FLAG = 1;
    localparam int HS_IRQ  = 2;
    localparam int HS_GEN  = 3;

    typedef struct packed {
        logic a_strobed;
        logic a_in;
        logic cu_in;
        logic b_strobed;
        logic b_in;
        logic cl_in;
    } mode_t;

    localparam mode_t MODE_RESET = '{a_strobed: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                     b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    typedef struct packed {
        mode_t         mode;
        logic [DW-1:0] lat_a;
        logic [DW-1:0] lat_b;
        logic [DW-1:0] lat_c;
    } top_st_t;

    function automatic mode_t decode_mode(input logic [DW-1:0] w);
        mode_t m;
        m.a_strobed = w[6];
        m.a_in      = w[5];
        m.cu_in     = w[4];
        m.b_strobed = w[3];
        m.b_in      = w[2];
        m.cl_in     = w[1];
        return m;
    endfunction
endpackage

// File: rtl/ppio_bus.sv
module ppio_bus (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic rd_go,
    output logic wr_go
);
    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } bus_st_t;

    bus_st_t s_d, s_q;
    logic    wr_act;

    always_comb begin
        rd_act    = !cs_n && !rd_n;
        wr_act    = !cs_n && !wr_n;
        rd_go     = rd_act && !s_q.rd_prev;
        wr_go     = wr_act && !s_q.wr_prev;
        s_d.rd_prev = rd_act;
        s_d.wr_prev = wr_act;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R2: one commit per strobe assertion
    p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !wr_go);
    p_single_read_r2: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go);
endmodule

// File: rtl/ppio_hs.sv
module ppio_hs
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strobed,
    input  logic          dir_in,
    input  logic          cfg_load,
    input  logic          mask_wr,
    input  logic          mask_val,
    input  logic          stb_n,
    input  logic          port_rd,
    input  logic          port_wr,
    input  logic [DW-1:0] pin_data,
    output logic [DW-1:0] in_latch,
    output logic          flag_pin,
    output logic          irq,
    output logic          mask
);
    typedef struct packed {
        logic [DW-1:0] lat;
        logic          ibf;
        logic          obf;
        logic          irq;
        logic          mask;
        logic          stb;
    } hs_st_t;

    hs_st_t s_d, s_q;
    logic   rise;

    always_comb begin
        s_d   = s_q;
        s_d.stb = stb_n;
        rise  = stb_n && !s_q.stb;
        if (cfg_load) begin
            s_d.ibf  = 1'b0;
            s_d.obf  = 1'b0;
            s_d.irq  = 1'b0;
            s_d.mask = 1'b0;
        end else begin
            if (mask_wr) s_d.mask = mask_val;
            if (strobed && dir_in) begin
                if (port_rd) begin
                    s_d.ibf = 1'b0;
                    s_d.irq = 1'b0;
                end
                if (!stb_n) begin
                    s_d.ibf = 1'b1;
                    s_d.lat = pin_data;
                end
                if (rise && s_d.ibf && s_q.mask) s_d.irq = 1'b1;
            end else if (strobed) begin
                if (!stb_n) s_d.obf = 1'b0;
                if (port_wr) begin
                    s_d.obf = 1'b1;
                    s_d.irq = 1'b0;
                end
                if (rise && !s_d.obf && s_q.mask) s_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{lat: '0, ibf: 1'b0, obf: 1'b0, irq: 1'b0, mask: 1'b0, stb: 1'b1};
        else     s_q <= s_d;
    end

    assign in_latch = s_q.lat;
    assign flag_pin = dir_in ? s_q.ibf : !s_q.obf;
    assign irq      = s_q.irq;
    assign mask     = s_q.mask;

    // R9: a read with the strobe released empties the buffer
    p_read_empties_r9: assert property (@(posedge clk) disable iff (rst)
        (strobed && dir_in && !cfg_load && port_rd && stb_n) |=> !s_q.ibf);
    // R13: an interrupt only rises while the mask was set
    p_irq_needs_mask_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.irq) |-> $past(s_q.mask));
    // R10: a write fills the output buffer
    p_write_fills_r10: assert property (@(posedge clk) disable iff (rst)
        (strobed && !dir_in && !cfg_load && port_wr) |=> (s_q.obf && !s_q.irq));
    // R7: a mode definition clears the handshake state
    p_cfg_clears_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (!s_q.mask && !s_q.irq && !s_q.ibf && !s_q.obf));
endmodule

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_cs_n,
    input  logic          bus_rd_n,
    input  logic          bus_wr_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic          pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    top_st_t t_d, t_q;
    logic    rd_act, rd_go, wr_go;
    logic    cfg_load, bsr_go;
    logic [IDXW-1:0] bsr_idx;

    logic [NGRP-1:0] g_strobed, g_in, g_nib_in, g_mask_wr, g_rd, g_wr, g_stb;
    logic [NGRP-1:0] g_flag, g_irq, g_mask;
    logic [DW-1:0]   g_pin [NGRP];
    logic [DW-1:0]   g_lat [NGRP];

    ppio_bus u_bus (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (bus_cs_n),
        .rd_n   (bus_rd_n),
        .wr_n   (bus_wr_n),
        .rd_act (rd_act),
        .rd_go  (rd_go),
        .wr_go  (wr_go)
    );

    assign cfg_load = wr_go && (bus_addr == ADR_CTL) && bus_wdata[DW-1];
    assign bsr_go   = wr_go && (bus_addr == ADR_CTL) && !bus_wdata[DW-1];
    assign bsr_idx  = bus_wdata[IDXW:1];

    // group 0 = A (upper nibble), group 1 = B (lower nibble)
    assign g_strobed = {t_q.mode.b_strobed, t_q.mode.a_strobed};
    assign g_in      = {t_q.mode.b_in, t_q.mode.a_in};
    assign g_nib_in  = {t_q.mode.cl_in, t_q.mode.cu_in};
    assign g_rd      = {rd_go && (bus_addr == ADR_B), rd_go && (bus_addr == ADR_A)};
    assign g_wr      = {wr_go && (bus_addr == ADR_B), wr_go && (bus_addr == ADR_A)};
    assign g_pin[0]  = pa_in;
    assign g_pin[1]  = pb_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int BASE = (NGRP - 1 - g) * HALF;

        assign g_stb[g]     = pc_in[BASE + HS_STB];
        assign g_mask_wr[g] = bsr_go && (int'(bsr_idx) == BASE + HS_STB);

        ppio_hs u_hs (
            .clk      (clk),
            .rst      (rst),
            .strobed  (g_strobed[g]),
            .dir_in   (g_in[g]),
            .cfg_load (cfg_load),
            .mask_wr  (g_mask_wr[g]),
            .mask_val (bus_wdata[0]),
            .stb_n    (g_stb[g]),
            .port_rd  (g_rd[g]),
            .port_wr  (g_wr[g]),
            .pin_data (g_pin[g]),
            .in_latch (g_lat[g]),
            .flag_pin (g_flag[g]),
            .irq      (g_irq[g]),
            .mask     (g_mask[g])
        );

        always_comb begin
            if (g_strobed[g]) begin
                pc_oe[BASE +: HALF]  = {!g_nib_in[g], 1'b1, 1'b1, 1'b0};
                pc_out[BASE +: HALF] = {t_q.lat_c[BASE + HS_GEN], g_irq[g], g_flag[g],
                                        t_q.lat_c[BASE + HS_STB]};
            end else begin
                pc_oe[BASE +: HALF]  = {HALF{!g_nib_in[g]}};
                pc_out[BASE +: HALF] = t_q.lat_c[BASE +: HALF];
            end
        end
    end

    always_comb begin
        t_d = t_q;
        if (wr_go) begin
            case (bus_addr)
                ADR_A:   t_d.lat_a = bus_wdata;
                ADR_B:   t_d.lat_b = bus_wdata;
                ADR_C:   t_d.lat_c = bus_wdata;
                default: begin
                    if (bus_wdata[DW-1]) begin
                        t_d.mode  = decode_mode(bus_wdata);
                        t_d.lat_a = '0;
                        t_d.lat_b = '0;
                        t_d.lat_c = '0;
                    end else begin
                        t_d.lat_c[bsr_idx] = bus_wdata[0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '{mode: MODE_RESET, lat_a: '0, lat_b: '0, lat_c: '0};
        else     t_q <= t_d;
    end

    assign pa_out = t_q.lat_a;
    assign pb_out = t_q.lat_b;
    assign pa_oe  = !t_q.mode.a_in;
    assign pb_oe  = !t_q.mode.b_in;

    always_comb begin
        case (bus_addr)
            ADR_A:   bus_rdata = !t_q.mode.a_in ? t_q.lat_a :
                                 (t_q.mode.a_strobed ? g_lat[0] : pa_in);
            ADR_B:   bus_rdata = !t_q.mode.b_in ? t_q.lat_b :
                                 (t_q.mode.b_strobed ? g_lat[1] : pb_in);
            ADR_C:   bus_rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
            default: bus_rdata = '0;
        endcase
        bus_rdata_oe = rd_act && (bus_addr != ADR_CTL);
    end

    // R3: control register is never read back
    p_ctrl_hidden_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_CTL) |-> !bus_rdata_oe);
    // R2: no bus drive without chip select
    p_no_drive_idle_r2: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> !bus_rdata_oe);
    // R6: a bit set/reset command leaves the modes alone
    p_bsr_keeps_mode_r6: assert property (@(posedge clk) disable iff (rst)
        bsr_go |=> $stable(t_q.mode));
    // R4: a mode word makes port B follow its direction field
    p_mode_dir_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (pb_oe == !$past(bus_wdata[2])));
endmodule

// File: tb/sim_par_io_ctrl.sv
`timescale 1ns/1ps
module sim_par_io_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;
    int         errors = 0;
    int         checks = 0;

    always #2.5 clk = !clk;

    par_io_ctrl u0 (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .bus_rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // rows: {mode word, value written to A, pin A, expected read, expected pa_out}
    localparam logic [39:0] VEC [4] = '{
        {8'hA0, 8'h55, 8'h3C, 8'h3C, 8'h55},
        {8'h80, 8'hAA, 8'h0F, 8'hAA, 8'hAA},
        {8'h80, 8'h00, 8'hFF, 8'h00, 8'h00},
        {8'hA0, 8'h12, 8'hF0, 8'hF0, 8'h12}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wd = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        v = rdata; oe = rdata_oe;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe_pulse(input int bitpos);
        @(negedge clk);
        pc_in[bitpos] = 1'b0;
        @(negedge clk);
        pc_in[bitpos] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       oe;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pa_oe", {7'b0, pa_oe}, 8'h00);
        chk("R1 pb_oe", {7'b0, pb_oe}, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 latch", pb_out, 8'h00);

        // R4 all outputs basic
        bus_wr(2'd3, 8'h80);
        chk("R4 oe all", {5'b0, pa_oe, pb_oe, 1'b0} | {7'b0, &pc_oe}, 8'h07);
        chk("R1 pc latch zero", pc_out, 8'h00);

        // R2 write needs chip select
        @(negedge clk);
        addr = 2'd1; wd = 8'h77; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R2 no cs write", pb_out, 8'h00);
        bus_wr(2'd1, 8'h5A);
        chk("R2 write B", pb_out, 8'h5A);
        @(negedge clk);
        addr = 2'd1; rd_n = 1'b0;
        #1 chk("R2 no cs read drive", {7'b0, rdata_oe}, 8'h00);
        @(negedge clk);
        rd_n = 1'b1;

        // R3 control read not driven
        bus_rd(2'd3, v, oe);
        chk("R3 ctrl oe", {7'b0, oe}, 8'h00);

        // R7 mode word clears latches
        bus_wr(2'd3, 8'h80);
        chk("R7 latch cleared", pb_out, 8'h00);

        // R6 bit set/reset
        bus_wr(2'd3, 8'h0B);
        chk("R6 set bit5", pc_out, 8'h20);
        chk("R6 mode kept", {7'b0, pb_oe}, 8'h01);
        bus_wr(2'd3, 8'h0A);
        chk("R6 clear bit5", pc_out, 8'h00);

        // R5 table walk over basic modes
        for (int i = 0; i < 4; i++) begin
            bus_wr(2'd3, VEC[i][39:32]);
            bus_wr(2'd0, VEC[i][31:24]);
            pa_in = VEC[i][23:16];
            bus_rd(2'd0, v, oe);
            chk($sformatf("R5 row%0d read", i), v, VEC[i][15:8]);
            chk($sformatf("R5 row%0d out", i), pa_out, VEC[i][7:0]);
        end

        // R8/R9/R12 strobed input on group A
        bus_wr(2'd3, 8'hE0);
        chk("R12 pc_oe A strobed", pc_oe, 8'hEF);
        bus_wr(2'd3, 8'h09);
        pa_in = 8'h5A;
        @(negedge clk);
        pc_in[4] = 1'b0;
        @(negedge clk);
        chk("R8 ibf set", {7'b0, pc_out[5]}, 8'h01);
        chk("R9 no irq yet", {7'b0, pc_out[6]}, 8'h00);
        pc_in[4] = 1'b1;
        @(negedge clk);
        chk("R9 irq on release", {7'b0, pc_out[6]}, 8'h01);
        pa_in = 8'h00;
        bus_rd(2'd0, v, oe);
        chk("R8 latched data", v, 8'h5A);
        chk("R9 ibf cleared", {7'b0, pc_out[5]}, 8'h00);
        chk("R9 irq cleared", {7'b0, pc_out[6]}, 8'h00);

        // R13 mask cleared blocks interrupt
        bus_wr(2'd3, 8'h08);
        strobe_pulse(4);
        chk("R13 masked irq", {7'b0, pc_out[6]}, 8'h00);
        chk("R13 ibf still set", {7'b0, pc_out[5]}, 8'h01);
        bus_rd(2'd0, v, oe);

        // R11 read meets strobe release
        bus_wr(2'd3, 8'h09);
        @(negedge clk);
        pc_in[4] = 1'b0;
        @(negedge clk);
        pc_in[4] = 1'b1; addr = 2'd0; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R11 read wins irq", {7'b0, pc_out[6]}, 8'h00);
        chk("R11 read wins ibf", {7'b0, pc_out[5]}, 8'h00);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // R10/R12 strobed output on group B
        bus_wr(2'd3, 8'hA8);
        chk("R12 pc_oe B strobed", {4'b0, pc_oe[3:0]}, 8'h0E);
        chk("R10 obf idle high", {7'b0, pc_out[1]}, 8'h01);
        bus_wr(2'd3, 8'h01);
        bus_wr(2'd1, 8'h3C);
        chk("R10 data out", pb_out, 8'h3C);
        chk("R10 obf low", {7'b0, pc_out[1]}, 8'h00);
        @(negedge clk);
        pc_in[0] = 1'b0;
        @(negedge clk);
        chk("R10 ack empties", {7'b0, pc_out[1]}, 8'h01);
        chk("R10 no irq during ack", {7'b0, pc_out[2]}, 8'h00);
        pc_in[0] = 1'b1;
        @(negedge clk);
        chk("R10 irq on ack end", {7'b0, pc_out[2]}, 8'h01);
        bus_wr(2'd1, 8'hC3);
        chk("R10 write clears irq", {7'b0, pc_out[2]}, 8'h00);
        chk("R10 obf low again", {7'b0, pc_out[1]}, 8'h00);

        // R11 write meets acknowledge
        bus_rd(2'd0, v, oe);
        @(negedge clk);
        pc_in[0] = 1'b0;
        @(negedge clk);
        pc_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 irq before clash", {7'b0, pc_out[2]}, 8'h01);
        @(negedge clk);
        pc_in[0] = 1'b0; addr = 2'd1; wd = 8'h99; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        pc_in[0] = 1'b1; cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R11 write wins obf", {7'b0, pc_out[1]}, 8'h00);
        chk("R11 write wins irq", {7'b0, pc_out[2]}, 8'h00);

        // R7 mode word clears mask and flags
        bus_wr(2'd3, 8'hA8);
        chk("R7 obf cleared", {7'b0, pc_out[1]}, 8'h01);
        strobe_pulse(0);
        chk("R7 mask cleared", {7'b0, pc_out[2]}, 8'h00);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule